// File: doc/BRIEF.md
# NOR Flash Program/Erase Sequencer

This block sits on the host side of a 16-bit asynchronous NOR flash bus. It drives the address, write data, chip enable, write enable and output enable lines, and it turns a single request into a complete flash operation. The four operations are word program, sector erase, block erase and whole-device erase. Requests arrive on a valid/ready handshake. For each request the block issues the unlock and command writes the operation needs, with strobe widths set in clock cycles by parameters. It then reads the target location repeatedly until the toggling status bit stops changing.

A stable pair of reads is not trusted at once. Completion can fall in the middle of a read and produce a false match, so the block requires two further reads that also agree before it reports success. A per-operation timeout limits the polling. When the timeout expires, the block completes the bus cycle in progress and reports an error.

Top module: `nor_wr_seq`

## Requirements
- R1: A program request (req_op = 0) produces exactly four writes in this order: data 0xAA at address 0x555, 0x55 at 0x2AA, 0xA0 at 0x555, then req_data at req_addr. The unlock addresses have every bit above bit 11 at zero.
- R2: An erase request produces exactly six writes: 0xAA@0x555, 0x55@0x2AA, 0x80@0x555, 0xAA@0x555, 0x55@0x2AA. The sixth write is 0x30 at req_addr for a sector (req_op = 1), 0x50 at req_addr for a block (req_op = 2), or 0x10 at 0x555 for the whole device (req_op = 3).
- R3: After the last write, the block issues only reads, all at req_addr. It compares bit 6 of each read with bit 6 of the previous read.
- R4: The first matching pair must be followed by two more reads whose bit 6 also matches. Any mismatch restarts the count. Success is never reported while bit 6 is still toggling, even if a transient match occurs.
- R5: Every write-enable low pulse lasts at least T_WP clock cycles.
- R6: Write enable stays high for at least T_WPH cycles between pulses.
- R7: While write enable is low, the address and write data stay constant and the data drivers stay enabled.
- R8: Output enable and write enable are never low together. Either strobe is low only while chip enable is low. The data drivers are off whenever output enable is low.
- R9: Polling is limited to TO_PROG cycles for a program, TO_ERASE cycles for a sector or block erase, and TO_CHIP cycles for a device erase. On expiry the block finishes the current read, reports op_done with op_err = 1, and leaves all strobes high.
- R10: req_ready is high only when the block is idle. A request is taken when req_valid and req_ready are both high. While an operation runs, requests have no effect on the bus.
- R11: op_done is a one-cycle pulse. op_err is high only together with op_done, and is 0 on success.
- R12: During reset: req_ready = 1, op_done = 0, chip enable, write enable and output enable are all high, and the data drivers are off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, can accept a request |
| req_op | input | 2 | 0 program, 1 sector erase, 2 block erase, 3 device erase |
| req_addr | input | AW | Word address (program) or sector/block address |
| req_data | input | DW | Word to program |
| op_done | output | 1 | One-cycle completion pulse |
| op_err | output | 1 | Timeout indication, valid with op_done |
| fl_addr | output | AW | Flash address |
| fl_dq_out | output | DW | Write data toward flash |
| fl_dq_oe | output | 1 | Enables the host data drivers |
| fl_dq_in | input | DW | Read data from flash |
| fl_ce_n | output | 1 | Chip enable, active low |
| fl_we_n | output | 1 | Write enable, active low |
| fl_oe_n | output | 1 | Output enable, active low |

## Verification
Errors in the beat index or in the operation held for the request show up on the flash bus within the first six write pulses, as a wrong address/data pair or a wrong number of writes. Errors in the stability counter or in the last-bit-6 register show up at op_done. The pulse comes either before the modelled device stops toggling, or, when a false match has been injected, only three reads after it. A timer loaded with the wrong limit shows as op_done arriving too early, or as an error where a success was expected, within one timeout window. Strobe-width and overlap faults show on the very first bus cycle.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

  typedef enum logic [1:0] {
    OP_PROG = 2'd0,
    OP_SECT = 2'd1,
    OP_BLK  = 2'd2,
    OP_CHIP = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_SETUP,
    PH_STROBE,
    PH_RECOV
  } phase_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_WR,
    S_WRW,
    S_RD,
    S_RDW
  } seq_e;

  // one command write: low address bits or the request address, plus data
  typedef struct packed {
    logic        use_req;
    logic [11:0] lo;
    logic [15:0] data;
  } wr_beat_t;

  localparam logic [11:0] UNL_A = 12'h555;
  localparam logic [11:0] UNL_B = 12'h2AA;

  function automatic logic [2:0] beat_count(op_e op);
    return (op == OP_PROG) ? 3'd4 : 3'd6;
  endfunction

  function automatic wr_beat_t beat(op_e op, logic [2:0] idx, logic [15:0] wdata);
    wr_beat_t b;
    b = '{use_req: 1'b0, lo: UNL_A, data: 16'h00AA};
    if (op == OP_PROG) begin
      case (idx)
        3'd1:    b = '{use_req: 1'b0, lo: UNL_B, data: 16'h0055};
        3'd2:    b = '{use_req: 1'b0, lo: UNL_A, data: 16'h00A0};
        3'd3:    b = '{use_req: 1'b1, lo: 12'h000, data: wdata};
        default: b = '{use_req: 1'b0, lo: UNL_A, data: 16'h00AA};
      endcase
    end else begin
      case (idx)
        3'd1, 3'd4: b = '{use_req: 1'b0, lo: UNL_B, data: 16'h0055};
        3'd2:       b = '{use_req: 1'b0, lo: UNL_A, data: 16'h0080};
        3'd5: begin
          if (op == OP_CHIP)      b = '{use_req: 1'b0, lo: UNL_A, data: 16'h0010};
          else if (op == OP_SECT) b = '{use_req: 1'b1, lo: 12'h000, data: 16'h0030};
          else                    b = '{use_req: 1'b1, lo: 12'h000, data: 16'h0050};
        end
        default:    b = '{use_req: 1'b0, lo: UNL_A, data: 16'h00AA};
      endcase
    end
    return b;
  endfunction

endpackage

// File: rtl/nor_bus_cycle.sv
// One asynchronous bus cycle: setup, strobe, recovery, all timed in clocks.
module nor_bus_cycle
  import nor_seq_pkg::*;
#(
  parameter int AW    = 20,
  parameter int DW    = 16,
  parameter int T_AS  = 1,
  parameter int T_WP  = 2,
  parameter int T_WPH = 2,
  parameter int T_RD  = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          done,
  output logic [DW-1:0] rdata,
  output logic [AW-1:0] fl_addr,
  output logic [DW-1:0] fl_dq_out,
  output logic          fl_dq_oe,
  input  logic [DW-1:0] fl_dq_in,
  output logic          fl_ce_n,
  output logic          fl_we_n,
  output logic          fl_oe_n
);

  localparam int M1   = (T_AS > T_WP) ? T_AS : T_WP;
  localparam int M2   = (T_WPH > T_RD) ? T_WPH : T_RD;
  localparam int PMAX = (M1 > M2) ? M1 : M2;
  localparam int CW   = $clog2(PMAX + 1);

  phase_e        ph;
  logic [CW-1:0] cnt;
  logic          wr_q;

  always_ff @(posedge clk) begin
    done <= 1'b0;
    if (rst) begin
      ph        <= PH_IDLE;
      cnt       <= '0;
      wr_q      <= 1'b0;
      fl_addr   <= '0;
      fl_dq_out <= '0;
      fl_dq_oe  <= 1'b0;
      fl_ce_n   <= 1'b1;
      fl_we_n   <= 1'b1;
      fl_oe_n   <= 1'b1;
      rdata     <= '0;
    end else begin
      unique case (ph)
        PH_IDLE: if (start) begin
          fl_addr   <= addr;
          fl_dq_out <= wdata;
          fl_dq_oe  <= wr;
          fl_ce_n   <= 1'b0;
          wr_q      <= wr;
          cnt       <= CW'(T_AS - 1);
          ph        <= PH_SETUP;
        end
        PH_SETUP: begin
          if (cnt == '0) begin
            ph <= PH_STROBE;
            if (wr_q) begin
              fl_we_n <= 1'b0;
              cnt     <= CW'(T_WP - 1);
            end else begin
              fl_oe_n <= 1'b0;
              cnt     <= CW'(T_RD - 1);
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        PH_STROBE: begin
          if (cnt == '0) begin
            if (!wr_q) rdata <= fl_dq_in;
            fl_we_n  <= 1'b1;
            fl_oe_n  <= 1'b1;
            fl_ce_n  <= 1'b1;
            fl_dq_oe <= 1'b0;
            cnt      <= CW'(T_WPH - 1);
            ph       <= PH_RECOV;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        PH_RECOV: begin
          if (cnt == '0) begin
            ph   <= PH_IDLE;
            done <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/nor_op_timer.sv
// Counts polling cycles and flags when the limit is reached.
module nor_op_timer #(
  parameter int TW = 22
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          run,
  input  logic [TW-1:0] limit,
  output logic          expired
);

  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt     <= '0;
      expired <= 1'b0;
    end else if (run && !expired) begin
      cnt     <= cnt + TW'(1);
      expired <= ((cnt + TW'(1)) >= limit);
    end
  end

endmodule

// File: rtl/nor_wr_seq.sv
module nor_wr_seq
  import nor_seq_pkg::*;
#(
  parameter int AW       = 20,
  parameter int DW       = 16,
  parameter int T_AS     = 1,
  parameter int T_WP     = 2,
  parameter int T_WPH    = 2,
  parameter int T_RD     = 4,
  parameter int TO_PROG  = 600,
  parameter int TO_ERASE = 1250000,
  parameter int TO_CHIP  = 2500000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  output logic          op_done,
  output logic          op_err,
  output logic [AW-1:0] fl_addr,
  output logic [DW-1:0] fl_dq_out,
  output logic          fl_dq_oe,
  input  logic [DW-1:0] fl_dq_in,
  output logic          fl_ce_n,
  output logic          fl_we_n,
  output logic          fl_oe_n
);

  localparam int TGL_BIT   = 6;
  localparam int CONFIRM_N = 2;
  localparam int TO_M1     = (TO_PROG > TO_ERASE) ? TO_PROG : TO_ERASE;
  localparam int TO_MAX    = (TO_M1 > TO_CHIP) ? TO_M1 : TO_CHIP;
  localparam int TW        = $clog2(TO_MAX + 1);

  seq_e          st;
  op_e           op_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic [2:0]    idx_q;
  logic          prev_q;
  logic          have_q;
  logic [1:0]    stab_q;

  logic          cyc_start, cyc_wr, cyc_done;
  logic [AW-1:0] cyc_addr;
  logic [DW-1:0] cyc_wdata, cyc_rdata;
  wr_beat_t      bt;
  logic [TW-1:0] to_limit;
  logic          to_exp;
  logic          rd_match;

  always_comb begin
    bt        = beat(op_q, idx_q, 16'(data_q));
    cyc_start = (st == S_WR) || (st == S_RD);
    cyc_wr    = (st == S_WR);
    cyc_wdata = DW'(bt.data);
    if ((st == S_WR) && !bt.use_req) cyc_addr = AW'(bt.lo);
    else                             cyc_addr = addr_q;
    unique case (op_q)
      OP_PROG: to_limit = TW'(TO_PROG);
      OP_CHIP: to_limit = TW'(TO_CHIP);
      default: to_limit = TW'(TO_ERASE);
    endcase
    rd_match = have_q && (cyc_rdata[TGL_BIT] == prev_q);
  end

  nor_bus_cycle #(
    .AW(AW), .DW(DW), .T_AS(T_AS), .T_WP(T_WP), .T_WPH(T_WPH), .T_RD(T_RD)
  ) u_bus (
    .clk(clk), .rst(rst), .start(cyc_start), .wr(cyc_wr),
    .addr(cyc_addr), .wdata(cyc_wdata), .done(cyc_done), .rdata(cyc_rdata),
    .fl_addr(fl_addr), .fl_dq_out(fl_dq_out), .fl_dq_oe(fl_dq_oe),
    .fl_dq_in(fl_dq_in), .fl_ce_n(fl_ce_n), .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n)
  );

  nor_op_timer #(.TW(TW)) u_tmr (
    .clk(clk), .rst(rst),
    .clr(st == S_IDLE),
    .run((st == S_RD) || (st == S_RDW)),
    .limit(to_limit),
    .expired(to_exp)
  );

  always_ff @(posedge clk) begin
    op_done <= 1'b0;
    op_err  <= 1'b0;
    if (rst) begin
      st        <= S_IDLE;
      op_q      <= OP_PROG;
      addr_q    <= '0;
      data_q    <= '0;
      idx_q     <= '0;
      prev_q    <= 1'b0;
      have_q    <= 1'b0;
      stab_q    <= '0;
      req_ready <= 1'b1;
    end else begin
      unique case (st)
        S_IDLE: if (req_valid && req_ready) begin
          op_q      <= op_e'(req_op);
          addr_q    <= req_addr;
          data_q    <= req_data;
          idx_q     <= '0;
          have_q    <= 1'b0;
          stab_q    <= '0;
          req_ready <= 1'b0;
          st        <= S_WR;
        end
        S_WR: st <= S_WRW;
        S_WRW: if (cyc_done) begin
          if (idx_q == beat_count(op_q) - 3'd1) begin
            st <= S_RD;
          end else begin
            idx_q <= idx_q + 3'd1;
            st    <= S_WR;
          end
        end
        S_RD: st <= S_RDW;
        S_RDW: if (cyc_done) begin
          prev_q <= cyc_rdata[TGL_BIT];
          have_q <= 1'b1;
          if (rd_match && (stab_q == 2'(CONFIRM_N))) begin
            op_done   <= 1'b1;
            req_ready <= 1'b1;
            st        <= S_IDLE;
          end else if (to_exp) begin
            op_done   <= 1'b1;
            op_err    <= 1'b1;
            req_ready <= 1'b1;
            st        <= S_IDLE;
          end else begin
            stab_q <= rd_match ? stab_q + 2'd1 : 2'd0;
            st     <= S_RD;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/nor_wr_seq_chk.sv
module nor_wr_seq_chk #(
  parameter int AW    = 20,
  parameter int DW    = 16,
  parameter int T_WP  = 2,
  parameter int T_WPH = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          req_ready,
  input logic          op_done,
  input logic          op_err,
  input logic [AW-1:0] fl_addr,
  input logic [DW-1:0] fl_dq_out,
  input logic          fl_dq_oe,
  input logic          fl_ce_n,
  input logic          fl_we_n,
  input logic          fl_oe_n
);

  localparam int CW = $clog2(T_WP + T_WPH + 1) + 1;

  logic [CW-1:0] lo_cnt, hi_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_cnt <= '0;
      hi_cnt <= '1;
    end else begin
      if (!fl_we_n) begin
        hi_cnt <= '0;
        if (lo_cnt != '1) lo_cnt <= lo_cnt + 1'b1;
      end else begin
        lo_cnt <= '0;
        if (hi_cnt != '1) hi_cnt <= hi_cnt + 1'b1;
      end
    end
  end

  a_r5_we_low_min: assert property (@(posedge clk) disable iff (rst)
    $rose(fl_we_n) |-> (lo_cnt >= CW'(T_WP)));

  a_r6_we_high_min: assert property (@(posedge clk) disable iff (rst)
    $fell(fl_we_n) |-> (hi_cnt >= CW'(T_WPH)));

  a_r7_hold_during_pulse: assert property (@(posedge clk) disable iff (rst)
    (!fl_we_n && $past(!fl_we_n)) |-> ($stable(fl_addr) && $stable(fl_dq_out) && fl_dq_oe));

  a_r8_no_overlap: assert property (@(posedge clk) disable iff (rst)
    !(!fl_we_n && !fl_oe_n));

  a_r8_strobe_needs_ce: assert property (@(posedge clk) disable iff (rst)
    (!fl_we_n || !fl_oe_n) |-> !fl_ce_n);

  a_r8_no_drive_on_read: assert property (@(posedge clk) disable iff (rst)
    !fl_oe_n |-> !fl_dq_oe);

  a_r9_bus_quiet_at_done: assert property (@(posedge clk) disable iff (rst)
    op_done |-> (fl_ce_n && fl_we_n && fl_oe_n));

  a_r10_ready_with_done: assert property (@(posedge clk) disable iff (rst)
    op_done |-> req_ready);

  a_r11_done_pulse: assert property (@(posedge clk) disable iff (rst)
    op_done |=> !op_done);

  a_r11_err_with_done: assert property (@(posedge clk) disable iff (rst)
    op_err |-> op_done);

endmodule

bind nor_wr_seq nor_wr_seq_chk #(
  .AW(AW), .DW(DW), .T_WP(T_WP), .T_WPH(T_WPH)
) u_chk (
  .clk(clk), .rst(rst), .req_ready(req_ready), .op_done(op_done), .op_err(op_err),
  .fl_addr(fl_addr), .fl_dq_out(fl_dq_out), .fl_dq_oe(fl_dq_oe),
  .fl_ce_n(fl_ce_n), .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n)
);

// File: tb/sim_nor_wr_seq.sv
module sim_nor_wr_seq;

  localparam int AW = 20;
  localparam int DW = 16;
  localparam int P_AS = 1, P_WP = 3, P_WPH = 2, P_RD = 3;
  localparam int P_TOP = 200, P_TOE = 400, P_TOC = 600;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [1:0]    req_op = 2'd0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic          op_done, op_err;
  logic [AW-1:0] fl_addr;
  logic [DW-1:0] fl_dq_out, fl_dq_in;
  logic          fl_dq_oe, fl_ce_n, fl_we_n, fl_oe_n;

  nor_wr_seq #(
    .AW(AW), .DW(DW), .T_AS(P_AS), .T_WP(P_WP), .T_WPH(P_WPH), .T_RD(P_RD),
    .TO_PROG(P_TOP), .TO_ERASE(P_TOE), .TO_CHIP(P_TOC)
  ) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_data(req_data),
    .op_done(op_done), .op_err(op_err), .fl_addr(fl_addr), .fl_dq_out(fl_dq_out),
    .fl_dq_oe(fl_dq_oe), .fl_dq_in(fl_dq_in), .fl_ce_n(fl_ce_n),
    .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---------------- flash device model ----------------
  int            cfg_nexp = 4;
  int            cfg_busy = 0;
  bit            cfg_glitch = 1'b0;
  logic [AW-1:0] cfg_paddr = '0;

  int            nw = 0;
  logic [AW-1:0] wa [8];
  logic [DW-1:0] wd [8];
  bit            busy = 1'b0;
  int            busy_cnt = 0;
  int            busy_end = 0;
  bit            tog = 1'b0;
  int            rdn = 0;
  int            rd_bad = 0;
  logic          we_d = 1'b1, oe_d = 1'b1;
  logic [AW-1:0] la = '0;
  logic [DW-1:0] ld = '0;
  int            lo = 0, hi = 100;
  int            v5 = 0, v6 = 0, v7 = 0, v8 = 0;

  assign fl_dq_in = busy ? DW'({tog, 6'b0}) : DW'(16'h1234);

  always @(negedge clk) begin
    if (rst) begin
      nw = 0; busy = 1'b0; we_d = 1'b1; oe_d = 1'b1; lo = 0; hi = 100;
    end else begin
      if (req_valid && req_ready) begin
        nw = 0; busy = 1'b0; rdn = 0; tog = 1'b0; busy_end = 0;
      end
      if (!fl_we_n && !fl_oe_n) v8++;
      if ((!fl_we_n || !fl_oe_n) && fl_ce_n) v8++;
      if (!fl_oe_n && fl_dq_oe) v8++;
      if (!fl_we_n) begin
        if (!we_d && (fl_addr != la || fl_dq_out != ld || !fl_dq_oe)) v7++;
        if (we_d) begin
          if (hi < P_WPH) v6++;
          hi = 0;
        end
        la = fl_addr; ld = fl_dq_out; lo++;
      end else begin
        if (!we_d) begin
          if (lo < P_WP) v5++;
          lo = 0;
          if (nw < 8) begin wa[nw] = la; wd[nw] = ld; end
          nw++;
          if (nw == cfg_nexp) begin busy = 1'b1; busy_cnt = cfg_busy; end
        end
        hi++;
      end
      if (!fl_oe_n && fl_addr != cfg_paddr) rd_bad++;
      if (!oe_d && fl_oe_n && busy) begin
        if (!(cfg_glitch && rdn == 1)) tog = ~tog;
        rdn++;
      end
      if (busy) begin
        if (busy_cnt == 0) begin busy = 1'b0; busy_end = cyc; end
        else busy_cnt--;
      end
      we_d = fl_we_n; oe_d = fl_oe_n;
    end
  end

  // ---------------- expected command stream ----------------
  function automatic logic [AW-1:0] exp_a(input logic [1:0] op, input int i, input logic [AW-1:0] a);
    if (op == 2'd0) begin
      if (i == 3) return a;
      return (i == 1) ? AW'(12'h2AA) : AW'(12'h555);
    end
    if (i == 5) return (op == 2'd3) ? AW'(12'h555) : a;
    return (i == 1 || i == 4) ? AW'(12'h2AA) : AW'(12'h555);
  endfunction

  function automatic logic [DW-1:0] exp_d(input logic [1:0] op, input int i, input logic [DW-1:0] d);
    if (op == 2'd0) begin
      case (i)
        0: return 16'h00AA;
        1: return 16'h0055;
        2: return 16'h00A0;
        default: return d;
      endcase
    end
    case (i)
      0, 3: return 16'h00AA;
      1, 4: return 16'h0055;
      2: return 16'h0080;
      default: return (op == 2'd3) ? 16'h0010 : ((op == 2'd1) ? 16'h0030 : 16'h0050);
    endcase
  endfunction

  task automatic issue(input logic [1:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input int bl, input bit gl, output int t_acc);
    cfg_nexp = (op == 2'd0) ? 4 : 6;
    cfg_busy = bl; cfg_glitch = gl; cfg_paddr = a;
    @(negedge clk);
    req_op = op; req_addr = a; req_data = d; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    t_acc = cyc;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done(output int t_done, output logic e);
    int n = 0;
    while (!op_done && n < 5000) begin @(negedge clk); n++; end
    chk(op_done, "R9 completion reached", {31'd0, op_done}, 32'd1);
    t_done = cyc; e = op_err;
  endtask

  task automatic check_stream(input logic [1:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d);
    string tag;
    tag = (op == 2'd0) ? "R1" : "R2";
    chk(nw == cfg_nexp, {tag, " write count"}, nw, cfg_nexp);
    for (int i = 0; i < cfg_nexp && i < 8; i++) begin
      chk(wa[i] == exp_a(op, i, a), {tag, " write address"}, 32'(wa[i]), 32'(exp_a(op, i, a)));
      chk(wd[i] == exp_d(op, i, d), {tag, " write data"}, 32'(wd[i]), 32'(exp_d(op, i, d)));
    end
  endtask

  // op, addr, data, busy cycles, false-match injection
  localparam logic [54:0] VEC [6] = '{
    {2'd0, 20'h01234, 16'hBEEF, 16'd60,  1'b0},
    {2'd1, 20'h0A800, 16'h0000, 16'd150, 1'b0},
    {2'd2, 20'h48000, 16'h0000, 16'd150, 1'b0},
    {2'd3, 20'h00000, 16'h0000, 16'd300, 1'b0},
    {2'd0, 20'hFF555, 16'h1357, 16'd60,  1'b1},
    {2'd1, 20'h13000, 16'h0000, 16'd0,   1'b0}
  };

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int   ta, td;
    logic e;
    repeat (3) @(negedge clk);
    // R12: reset state
    chk(req_ready == 1'b1, "R12 ready in reset", req_ready, 1);
    chk(op_done == 1'b0, "R12 done in reset", op_done, 0);
    chk({fl_ce_n, fl_we_n, fl_oe_n} == 3'b111, "R12 strobes in reset", {fl_ce_n, fl_we_n, fl_oe_n}, 3'b111);
    chk(fl_dq_oe == 1'b0, "R12 drivers in reset", fl_dq_oe, 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    // table-driven operations (R1 R2 R3 R4 R11)
    for (int k = 0; k < 6; k++) begin
      issue(VEC[k][54:53], VEC[k][52:33], VEC[k][32:17], int'(VEC[k][16:1]), VEC[k][0], ta);
      wait_done(td, e);
      chk(e == 1'b0, "R11 no error on success", e, 0);
      chk(td > busy_end && busy_end != 0, "R4 done only after toggling stops", td, busy_end);
      chk(rd_bad == 0, "R3 polls target address", rd_bad, 0);
      check_stream(VEC[k][54:53], VEC[k][52:33], VEC[k][32:17]);
      @(negedge clk);
      chk(op_done == 1'b0, "R11 done is one cycle", op_done, 0);
    end

    // R10: requests during an operation are ignored
    issue(2'd0, 20'h00420, 16'hCAFE, 60, 1'b0, ta);
    chk(req_ready == 1'b0, "R10 not ready while busy", req_ready, 0);
    req_op = 2'd3; req_addr = 20'h00777; req_valid = 1'b1;
    repeat (20) @(negedge clk);
    req_valid = 1'b0;
    wait_done(td, e);
    chk(req_ready == 1'b1, "R10 ready after done", req_ready, 1);
    chk(nw == 4 && wd[3] == 16'hCAFE && wa[3] == 20'h00420, "R10 extra request had no effect",
        {nw[15:0], wd[3]}, {16'd4, 16'hCAFE});

    // R9: timeout
    issue(2'd0, 20'h00100, 16'h0001, 60000, 1'b0, ta);
    wait_done(td, e);
    chk(e == 1'b1, "R9 error on timeout", e, 1);
    chk((td - ta) >= P_TOP && (td - ta) <= P_TOP + 150, "R9 timeout window", td - ta, P_TOP);
    chk({fl_ce_n, fl_we_n, fl_oe_n} == 3'b111, "R9 bus idle after timeout",
        {fl_ce_n, fl_we_n, fl_oe_n}, 3'b111);
    @(negedge clk);
    chk(op_done == 1'b0 && op_err == 1'b0, "R11 error pulse ends", {op_done, op_err}, 0);

    chk(v5 == 0, "R5 write pulse width", v5, 0);
    chk(v6 == 0, "R6 write high gap", v6, 0);
    chk(v7 == 0, "R7 address/data held", v7, 0);
    chk(v8 == 0, "R8 strobe rules", v8, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule